// File: doc/BRIEF.md
# Barrier-Aware Dual-Class Write Scheduler

This block sits in the write path of a memory controller for a multi-bank non-volatile main memory. That memory holds two kinds of data. Working data can be lost at power-down without harm. Persistent data must reach the cells in an order that software controls. Each write that enters the scheduler is tagged as working or persistent when it is enqueued. The tag comes from a one-bit-per-frame class table that software loads through a small configuration port.

Software orders its persistent updates by raising a barrier request. A barrier does not take a queue slot. It advances an epoch counter, and every queued write records the epoch that was current when it arrived. A persistent write may start only after every persistent write from an older epoch has left the queue and finished in its bank. Working writes never wait on a barrier, so they keep idle banks busy while persistent traffic is held back. While any barrier is still open, a persistent write that can start takes precedence over a working write that can start.

Each cycle the scheduler offers at most one write on a valid/ready issue port. That write goes to a bank that is idle. Consecutive writes can go to different banks while earlier ones are still in progress.

Top module: `wsched_top`

## Requirements
- R1: The class of a write is fixed at enqueue from the class-table bit of its frame, the frame being address bits [11:9]. A bit value of 1 means persistent and 0 means working. `iss_persist` carries that class when the write issues.
- R2: A class-table write through `map_we` changes the class of writes enqueued in later cycles. A write enqueued in the same cycle as the table write uses the old bit.
- R3: The queue holds 8 writes. `enq_ready` is low exactly when 8 writes are queued. An enqueue attempt while `enq_ready` is low leaves the queue unchanged.
- R4: The bank of a write is address bits [1:0]. After a write issues to a bank in cycle c, no write issues to that bank in cycles c+1 through c+4. The bank is free again from cycle c+5.
- R5: A persistent write enqueued after a barrier does not issue until every persistent write enqueued before that barrier has issued and its bank has become free again.
- R6: A working write issues to any free bank whatever barriers are open.
- R7: A barrier is open while any persistent write from an older epoch is queued or busy in a bank. While a barrier is open, an issuable persistent write is chosen over any issuable working write.
- R8: Among issuable writes of equal priority, the one enqueued earliest is offered first.
- R9: `iss_valid` is high in a cycle exactly when at least one queued write is issuable. At most one write is offered per cycle. Writes to different banks may issue in consecutive cycles.
- R10: After reset the queue is empty, `enq_ready` is high, `iss_valid` is low, all banks are free, the class table holds all zeros and the epoch is zero.
- R11: A barrier uses no queue slot. A write enqueued in the same cycle as a barrier belongs to the epoch before that barrier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | A write is offered for the queue |
| enq_ready | output | 1 | The queue has a free slot |
| enq_addr | input | 12 | Address of the offered write |
| barrier_req | input | 1 | Open a new ordering epoch |
| map_we | input | 1 | Write one class-table bit |
| map_frame | input | 3 | Frame whose class bit is written |
| map_persist | input | 1 | New class bit, 1 means persistent |
| iss_valid | output | 1 | A write is offered to the banks |
| iss_ready | input | 1 | The offered write is taken |
| iss_addr | output | 12 | Address of the offered write |
| iss_bank | output | 2 | Target bank of the offered write |
| iss_persist | output | 1 | Class of the offered write |

## Verification
The checks assume that no more than 15 barriers are raised between the oldest outstanding persistent write and the present. Epochs are stored modulo 16, and a wider spread would make a newer epoch look older. The stimulus tracks the spread of epochs in its own model and withholds barriers once that spread reaches 10. The assertions also assume `rst_n` is low at time zero. Apart from these limits the checks accept any input, including enqueue attempts on a full queue and `iss_ready` held low for long stretches, and the stimulus exercises both.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

  // distance of a stored epoch behind the current one, modulo 2**w
  function automatic int unsigned ring_age(int unsigned cur, int unsigned tag, int unsigned w);
    int unsigned mask;
    mask = (32'd1 << w) - 32'd1;
    return (cur - tag) & mask;
  endfunction

  // true when epoch a is strictly older than epoch b
  function automatic logic epoch_older(int unsigned cur, int unsigned a, int unsigned b,
                                       int unsigned w);
    return ring_age(cur, a, w) > ring_age(cur, b, w);
  endfunction

endpackage

// File: rtl/wsched_class_map.sv
module wsched_class_map #(
  parameter int FRAME_W = 3,
  localparam int NFRAME = 1 << FRAME_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [FRAME_W-1:0] cfg_frame,
  input  logic               cfg_bit,
  input  logic [FRAME_W-1:0] look_frame,
  output logic               look_persist
);
  logic [NFRAME-1:0] cls_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cls_q <= '0;
    else if (cfg_we) cls_q[cfg_frame] <= cfg_bit;
  end

  assign look_persist = cls_q[look_frame];
endmodule

// File: rtl/wsched_bank_timer.sv
module wsched_bank_timer #(
  parameter int NBANK   = 4,
  parameter int WLAT    = 4,
  parameter int EPOCH_W = 4,
  localparam int BANK_W = $clog2(NBANK),
  localparam int TMR_W  = $clog2(WLAT + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [BANK_W-1:0]               start_bank,
  input  logic                            start_persist,
  input  logic [EPOCH_W-1:0]              start_epoch,
  output logic [NBANK-1:0]                bank_free,
  output logic [NBANK-1:0]                fl_persist,
  output logic [NBANK-1:0][EPOCH_W-1:0]   fl_epoch
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [TMR_W-1:0] tmr_q;
    logic             hit;
    assign hit = start && (start_bank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tmr_q         <= '0;
        fl_persist[b] <= 1'b0;
        fl_epoch[b]   <= '0;
      end else if (hit) begin
        tmr_q         <= TMR_W'(WLAT);
        fl_persist[b] <= start_persist;
        fl_epoch[b]   <= start_epoch;
      end else if (tmr_q != '0) begin
        tmr_q <= tmr_q - TMR_W'(1);
      end
    end

    assign bank_free[b] = (tmr_q == '0);
  end
endmodule

// File: rtl/wsched_queue.sv
module wsched_queue #(
  parameter int QDEPTH  = 8,
  parameter int ADDR_W  = 12,
  parameter int EPOCH_W = 4,
  localparam int IDX_W  = $clog2(QDEPTH),
  localparam int CNT_W  = $clog2(QDEPTH + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           enq,
  input  logic [ADDR_W-1:0]              enq_addr,
  input  logic                           enq_persist,
  input  logic [EPOCH_W-1:0]             enq_epoch,
  input  logic                           deq,
  input  logic [IDX_W-1:0]               deq_idx,
  output logic [QDEPTH-1:0]              q_valid,
  output logic [QDEPTH-1:0][ADDR_W-1:0]  q_addr,
  output logic [QDEPTH-1:0]              q_persist,
  output logic [QDEPTH-1:0][EPOCH_W-1:0] q_epoch,
  output logic [CNT_W-1:0]               count
);
  logic [QDEPTH-1:0]              n_valid;
  logic [QDEPTH-1:0][ADDR_W-1:0]  n_addr;
  logic [QDEPTH-1:0]              n_persist;
  logic [QDEPTH-1:0][EPOCH_W-1:0] n_epoch;
  logic [CNT_W-1:0]               n_count;

  // index 0 is always the oldest entry; removal closes the gap
  always_comb begin
    int tail;
    for (int i = 0; i < QDEPTH; i++) begin
      int src;
      src = (deq && i >= int'(deq_idx) && i < QDEPTH - 1) ? i + 1 : i;
      n_valid[i]   = q_valid[src];
      n_addr[i]    = q_addr[src];
      n_persist[i] = q_persist[src];
      n_epoch[i]   = q_epoch[src];
      if (deq && i == QDEPTH - 1) n_valid[i] = 1'b0;
    end
    tail = int'(count) - (deq ? 1 : 0);
    for (int i = 0; i < QDEPTH; i++) begin
      if (enq && i == tail) begin
        n_valid[i]   = 1'b1;
        n_addr[i]    = enq_addr;
        n_persist[i] = enq_persist;
        n_epoch[i]   = enq_epoch;
      end
    end
    n_count = count + CNT_W'(enq) - CNT_W'(deq);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid   <= '0;
      q_addr    <= '0;
      q_persist <= '0;
      q_epoch   <= '0;
      count     <= '0;
    end else begin
      q_valid   <= n_valid;
      q_addr    <= n_addr;
      q_persist <= n_persist;
      q_epoch   <= n_epoch;
      count     <= n_count;
    end
  end
endmodule

// File: rtl/wsched_arbiter.sv
module wsched_arbiter #(
  parameter int QDEPTH  = 8,
  parameter int NBANK   = 4,
  parameter int EPOCH_W = 4,
  localparam int BANK_W = $clog2(NBANK),
  localparam int IDX_W  = $clog2(QDEPTH)
) (
  input  logic [QDEPTH-1:0]              q_valid,
  input  logic [QDEPTH-1:0][BANK_W-1:0]  q_bank,
  input  logic [QDEPTH-1:0]              q_persist,
  input  logic [QDEPTH-1:0][EPOCH_W-1:0] q_epoch,
  input  logic [NBANK-1:0]               bank_free,
  input  logic [NBANK-1:0]               fl_persist,
  input  logic [NBANK-1:0][EPOCH_W-1:0]  fl_epoch,
  input  logic [EPOCH_W-1:0]             cur_epoch,
  output logic [QDEPTH-1:0]              grant,
  output logic [IDX_W-1:0]               grant_idx,
  output logic                           any_grant,
  output logic                           barrier_open,
  output logic                           pers_ready_any
);
  import wsched_pkg::*;

  logic [QDEPTH-1:0] elig;
  logic [QDEPTH-1:0] pool;

  always_comb begin
    barrier_open = 1'b0;
    for (int j = 0; j < QDEPTH; j++)
      if (q_valid[j] && q_persist[j] && q_epoch[j] != cur_epoch) barrier_open = 1'b1;
    for (int b = 0; b < NBANK; b++)
      if (!bank_free[b] && fl_persist[b] && fl_epoch[b] != cur_epoch) barrier_open = 1'b1;

    for (int i = 0; i < QDEPTH; i++) begin
      elig[i] = q_valid[i] && bank_free[q_bank[i]];
      if (q_persist[i]) begin
        for (int j = 0; j < QDEPTH; j++)
          if (q_valid[j] && q_persist[j] &&
              epoch_older(int'(cur_epoch), int'(q_epoch[j]), int'(q_epoch[i]), EPOCH_W))
            elig[i] = 1'b0;
        for (int b = 0; b < NBANK; b++)
          if (!bank_free[b] && fl_persist[b] &&
              epoch_older(int'(cur_epoch), int'(fl_epoch[b]), int'(q_epoch[i]), EPOCH_W))
            elig[i] = 1'b0;
      end
    end

    pers_ready_any = |(elig & q_persist);
    pool = (barrier_open && pers_ready_any) ? (elig & q_persist) : elig;

    grant     = '0;
    grant_idx = '0;
    any_grant = 1'b0;
    for (int i = QDEPTH - 1; i >= 0; i--) begin
      if (pool[i]) begin
        grant     = '0;
        grant[i]  = 1'b1;
        grant_idx = IDX_W'(i);
        any_grant = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wsched_top.sv
module wsched_top #(
  parameter int ADDR_W  = 12,
  parameter int QDEPTH  = 8,
  parameter int NBANK   = 4,
  parameter int FRAME_W = 3,
  parameter int WLAT    = 4,
  parameter int EPOCH_W = 4,
  localparam int BANK_W = $clog2(NBANK),
  localparam int IDX_W  = $clog2(QDEPTH),
  localparam int CNT_W  = $clog2(QDEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enq_valid,
  output logic               enq_ready,
  input  logic [ADDR_W-1:0]  enq_addr,
  input  logic               barrier_req,
  input  logic               map_we,
  input  logic [FRAME_W-1:0] map_frame,
  input  logic               map_persist,
  output logic               iss_valid,
  input  logic               iss_ready,
  output logic [ADDR_W-1:0]  iss_addr,
  output logic [BANK_W-1:0]  iss_bank,
  output logic               iss_persist
);
  logic                           enq_fire, iss_fire, enq_cls;
  logic [EPOCH_W-1:0]             cur_epoch;
  logic [QDEPTH-1:0]              q_valid, q_persist, grant;
  logic [QDEPTH-1:0][ADDR_W-1:0]  q_addr;
  logic [QDEPTH-1:0][EPOCH_W-1:0] q_epoch;
  logic [QDEPTH-1:0][BANK_W-1:0]  q_bank;
  logic [CNT_W-1:0]               count;
  logic [IDX_W-1:0]               grant_idx;
  logic [NBANK-1:0]               bank_free, fl_persist;
  logic [NBANK-1:0][EPOCH_W-1:0]  fl_epoch;
  logic                           barrier_open, pers_ready_any;

  assign enq_ready = (count != CNT_W'(QDEPTH));
  assign enq_fire  = enq_valid && enq_ready;
  assign iss_fire  = iss_valid && iss_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) cur_epoch <= '0;
    else        cur_epoch <= cur_epoch + EPOCH_W'(barrier_req);
  end

  wsched_class_map #(.FRAME_W(FRAME_W)) u_map (
    .clk(clk), .rst_n(rst_n), .cfg_we(map_we), .cfg_frame(map_frame),
    .cfg_bit(map_persist), .look_frame(enq_addr[ADDR_W-1 -: FRAME_W]),
    .look_persist(enq_cls));

  wsched_queue #(.QDEPTH(QDEPTH), .ADDR_W(ADDR_W), .EPOCH_W(EPOCH_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .enq(enq_fire), .enq_addr(enq_addr),
    .enq_persist(enq_cls), .enq_epoch(cur_epoch), .deq(iss_fire),
    .deq_idx(grant_idx), .q_valid(q_valid), .q_addr(q_addr),
    .q_persist(q_persist), .q_epoch(q_epoch), .count(count));

  for (genvar i = 0; i < QDEPTH; i++) begin : g_bank_of
    assign q_bank[i] = q_addr[i][BANK_W-1:0];
  end

  wsched_arbiter #(.QDEPTH(QDEPTH), .NBANK(NBANK), .EPOCH_W(EPOCH_W)) u_arb (
    .q_valid(q_valid), .q_bank(q_bank), .q_persist(q_persist), .q_epoch(q_epoch),
    .bank_free(bank_free), .fl_persist(fl_persist), .fl_epoch(fl_epoch),
    .cur_epoch(cur_epoch), .grant(grant), .grant_idx(grant_idx),
    .any_grant(iss_valid), .barrier_open(barrier_open),
    .pers_ready_any(pers_ready_any));

  assign iss_addr    = q_addr[grant_idx];
  assign iss_bank    = q_bank[grant_idx];
  assign iss_persist = q_persist[grant_idx];

  wsched_bank_timer #(.NBANK(NBANK), .WLAT(WLAT), .EPOCH_W(EPOCH_W)) u_banks (
    .clk(clk), .rst_n(rst_n), .start(iss_fire), .start_bank(iss_bank),
    .start_persist(iss_persist), .start_epoch(q_epoch[grant_idx]),
    .bank_free(bank_free), .fl_persist(fl_persist), .fl_epoch(fl_epoch));
endmodule

// File: rtl/wsched_chk.sv
module wsched_chk #(
  parameter int QDEPTH = 8,
  parameter int NBANK  = 4,
  localparam int BANK_W = $clog2(NBANK),
  localparam int CNT_W  = $clog2(QDEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enq_valid,
  input logic              enq_ready,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic [BANK_W-1:0] iss_bank,
  input logic              iss_persist,
  input logic [CNT_W-1:0]  count,
  input logic [NBANK-1:0]  bank_free,
  input logic [QDEPTH-1:0] grant,
  input logic              barrier_open,
  input logic              pers_ready_any
);
  // R10
  reset_empty_chk: assert property (@(posedge clk) !rst_n |=> (count == '0));

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(QDEPTH));

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && !enq_ready && !(iss_valid && iss_ready)) |=> (count == $past(count)));

  // R4
  bank_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> !(iss_valid && iss_bank == $past(iss_bank)));

  // R4
  free_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> bank_free[iss_bank]);

  // R7
  persist_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_persist && barrier_open) |-> !pers_ready_any);

  // R9
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

bind wsched_top wsched_chk #(.QDEPTH(QDEPTH), .NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
  .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_bank(iss_bank),
  .iss_persist(iss_persist), .count(count), .bank_free(bank_free),
  .grant(grant), .barrier_open(barrier_open), .pers_ready_any(pers_ready_any));

// File: tb/test_wsched_top.sv
`timescale 1ns/1ps
module test_wsched_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enq_valid = 0, barrier_req = 0, map_we = 0, map_persist = 0, iss_ready = 0;
  logic [11:0] enq_addr = '0;
  logic [2:0]  map_frame = '0;
  logic enq_ready, iss_valid, iss_persist;
  logic [11:0] iss_addr;
  logic [1:0]  iss_bank;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wsched_top i_wsched_top (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_addr(enq_addr), .barrier_req(barrier_req), .map_we(map_we),
    .map_frame(map_frame), .map_persist(map_persist), .iss_valid(iss_valid),
    .iss_ready(iss_ready), .iss_addr(iss_addr), .iss_bank(iss_bank),
    .iss_persist(iss_persist));

  // behavioural reference: plain lists and integer epochs that never wrap
  int m_addr[$];
  bit m_pers[$];
  int m_ep[$];
  int busy[4];
  bit bpers[4];
  int bep[4];
  bit cls[8];
  int epoch_now;

  function automatic bit m_blocked(int ep);
    foreach (m_addr[k]) if (m_pers[k] && m_ep[k] < ep) return 1;
    for (int b = 0; b < 4; b++) if (busy[b] > 0 && bpers[b] && bep[b] < ep) return 1;
    return 0;
  endfunction

  function automatic int m_pick();
    bit open_bar = m_blocked(epoch_now);
    int first_any = -1, first_p = -1;
    foreach (m_addr[k]) begin
      if (busy[m_addr[k] % 4] != 0) continue;
      if (m_pers[k] && m_blocked(m_ep[k])) continue;
      if (first_any < 0) first_any = k;
      if (m_pers[k] && first_p < 0) first_p = k;
    end
    return (open_bar && first_p >= 0) ? first_p : first_any;
  endfunction

  task automatic check(string tag, string what, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic cycle(string tag, bit ev, int addr, bit bar, bit mwe, int mfr, bit mbit, bit rdy);
    int sel = m_pick();
    check("R3", {tag, " enq_ready"}, int'(enq_ready), int'(m_addr.size() < 8));
    check(tag, "iss_valid", int'(iss_valid), int'(sel >= 0));
    if (sel >= 0) begin
      check(tag, "iss_addr (R8)", int'(iss_addr), m_addr[sel]);
      check("R4", {tag, " iss_bank"}, int'(iss_bank), m_addr[sel] % 4);
      check("R1", {tag, " iss_persist"}, int'(iss_persist), int'(m_pers[sel]));
    end
    enq_valid = ev; enq_addr = 12'(addr); barrier_req = bar; map_we = mwe;
    map_frame = 3'(mfr); map_persist = mbit; iss_ready = rdy;
    @(posedge clk);
    begin
      bit full = (m_addr.size() >= 8);
      int lb = -1;
      if (sel >= 0 && rdy) begin
        lb = m_addr[sel] % 4;
        busy[lb] = 4; bpers[lb] = m_pers[sel]; bep[lb] = m_ep[sel];
        m_addr.delete(sel); m_pers.delete(sel); m_ep.delete(sel);
      end
      for (int b = 0; b < 4; b++) if (b != lb && busy[b] > 0) busy[b]--;
      if (ev && !full) begin
        m_addr.push_back(addr); m_pers.push_back(cls[addr >> 9]); m_ep.push_back(epoch_now);
      end
      if (mwe) cls[mfr] = mbit;
      if (bar) epoch_now++;
    end
    @(negedge clk);
  endtask

  function automatic int mk(int frame, int mid, int bank);
    return (frame << 9) | ((mid & 127) << 2) | bank;
  endfunction

  function automatic int spread();
    int lo = epoch_now;
    foreach (m_ep[k]) if (m_pers[k] && m_ep[k] < lo) lo = m_ep[k];
    for (int b = 0; b < 4; b++) if (busy[b] > 0 && bpers[b] && bep[b] < lo) lo = bep[b];
    return epoch_now - lo;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    epoch_now = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state seen at the ports
    check("R10", "enq_ready", int'(enq_ready), 1);
    check("R10", "iss_valid", int'(iss_valid), 0);
    // R2: mark frames 5 and 6 persistent; same-cycle enqueue uses the old bit
    cycle("R2", 1, mk(5, 1, 0), 0, 1, 5, 1, 0);
    cycle("R2", 1, mk(5, 2, 1), 0, 1, 6, 1, 0);
    cycle("R1", 1, mk(2, 3, 2), 0, 0, 0, 0, 0);
    cycle("R1", 1, mk(6, 4, 3), 0, 0, 0, 0, 0);
    repeat (6) cycle("R8", 0, 0, 0, 0, 0, 0, 1);
    // R4: same bank back to back
    for (int k = 0; k < 3; k++) cycle("R4", 1, mk(1, k, 0), 0, 0, 0, 0, 1);
    repeat (16) cycle("R4", 0, 0, 0, 0, 0, 0, 1);
    // R3: fill while the port is stalled, then keep pushing
    for (int k = 0; k < 11; k++) cycle("R3", 1, mk(k % 8, k, k % 4), 0, 0, 0, 0, 0);
    repeat (30) cycle("R9", 0, 0, 0, 0, 0, 0, 1);
    // R5 and R11: persistent, barrier in the same cycle as another persistent
    cycle("R11", 1, mk(5, 9, 0), 0, 0, 0, 0, 0);
    cycle("R11", 1, mk(5, 10, 1), 1, 0, 0, 0, 0);
    cycle("R5", 1, mk(5, 11, 2), 0, 0, 0, 0, 0);
    cycle("R6", 1, mk(2, 12, 3), 0, 0, 0, 0, 0);
    cycle("R7", 1, mk(2, 13, 2), 1, 0, 0, 0, 0);
    cycle("R7", 1, mk(6, 14, 3), 0, 0, 0, 0, 0);
    repeat (30) cycle("R5", 0, 0, 0, 0, 0, 0, 1);
    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      bit ev = ($urandom % 10) < 6;
      bit bar = (($urandom % 10) == 0) && (spread() < 10);
      bit mwe = ($urandom % 20) == 0;
      bit rdy = ($urandom % 10) < 8;
      cycle((n % 2) ? "R6" : "R7", ev, int'($urandom % 4096), bar, mwe,
            int'($urandom % 8), bit'($urandom % 2), rdy);
    end
    repeat (60) cycle("R9", 0, 0, 0, 0, 0, 0, 1);
    check("R9", "queue drained", int'(iss_valid), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule